// File: doc/BRIEF.md
# Reset-Cause Status Register

This block holds one 32-bit status word that records why the chip last restarted or woke. Five sticky flags are set by hardware event pulses: power-on, brown-out, entry into Idle, entry into Sleep, and watchdog expiry. A watchdog expiry also marks the power mode in which it happened. Once set, a flag stays set until software removes it.

Software reaches the word through four word slots on a simple bus. Slot 0 reads and writes the word directly. Slots 1, 2 and 3 are atomic aliases. Each one clears, sets or toggles only the bits written as 1, so a handler never needs a read-modify-write that could drop a flag raised in the meantime. When a hardware event and a software write touch the same flag in the same cycle, the hardware event wins.

Top module: `rstcause_reg`

## Requirements
- R1: After the asynchronous active-low reset, the word reads 0x0000_0003: bit 0 (power-on) and bit 1 (brown-out) are 1 and every other bit is 0.
- R2: A read with `rd_en` high at word slot 0 (byte offset 0x0) returns the word in the same cycle. A write at slot 0 replaces every implemented bit with the written value at the next clock edge.
- R3: A write at word slot 1 (byte offset 0x4) clears each implemented bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write at word slot 2 (byte offset 0x8) sets each implemented bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write at word slot 3 (byte offset 0xC) toggles each implemented bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R6: `rdata` is 0 for a read at slots 1, 2 or 3, and it is 0 whenever `rd_en` is low.
- R7: Only bits 4 to 0 are implemented. Bits 31 to 5 always read 0, and writing 1 to them through any slot changes nothing.
- R8: The event pulses set these flags at the next edge: `por_event` sets bit 0, `bor_event` sets bit 1, `idle_entry` sets bit 2 and `sleep_entry` sets bit 3. A flag holds its value in every cycle with no write and no event.
- R9: `wdt_expire` sets bit 4. It also sets bit 3 when `pwr_mode` is 2'b10 (Sleep) and bit 2 when `pwr_mode` is 2'b01 (Idle). With `pwr_mode` at 2'b00 (Run) or 2'b11 (reserved), it sets bit 4 alone.
- R10: When a hardware event sets a bit in the same cycle as a software write of any slot that would clear or toggle it, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_word | input | 2 | Word slot: 0 direct, 1 clear, 2 set, 3 toggle |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| pwr_mode | input | 2 | Power mode at expiry: 00 Run, 01 Idle, 10 Sleep, 11 reserved |
| sleep_entry | input | 1 | Pulse when the chip enters Sleep |
| idle_entry | input | 1 | Pulse when the chip enters Idle |
| bor_event | input | 1 | Brown-out pulse |
| por_event | input | 1 | Power-on event pulse |

## Verification
The assertions check the following on every cycle:
- a flag raised by hardware is present one cycle later, whatever software wrote;
- flags hold steady when there is neither a write nor an event;
- alias reads and reserved bits return zero;
- the set alias leaves the chosen bits set;
- the clear alias leaves them cleared when no event competes;
- a Sleep-time expiry raises both the watchdog flag and the Sleep flag.

Only the bench scenarios can show the exact result values:
- the full toggle and direct-write results, compared against a reference model;
- the reset value;
- the Idle and reserved-mode mapping of an expiry;
- the outcome of each alias colliding with an event in one cycle.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  // Word-slot meaning on the bus; the slot order is decoded by software.
  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_CLR    = 2'd1,
    OP_SET    = 2'd2,
    OP_INV    = 2'd3
  } alias_op_e;

  // Power mode reported alongside a watchdog expiry.
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_RSVD  = 2'd3
  } pwr_mode_e;

  // Flag positions: software decodes these, so they are fixed.
  localparam int BIT_POR   = 0;
  localparam int BIT_BOR   = 1;
  localparam int BIT_IDLE  = 2;
  localparam int BIT_SLEEP = 3;
  localparam int BIT_WDTO  = 4;

endpackage

// File: rtl/rstcause_alias_dec.sv
module rstcause_alias_dec
  import rstcause_pkg::*;
(
  input  logic [1:0] reg_word,
  input  logic       wr_en,
  input  logic       rd_en,
  output alias_op_e  op,
  output logic       wr_fire,
  output logic       rd_direct
);

  // The slot number maps straight onto the operation encoding.
  assign op        = alias_op_e'(reg_word);
  assign wr_fire   = wr_en;
  assign rd_direct = rd_en && (op == OP_DIRECT);

endmodule

// File: rtl/rstcause_event_map.sv
module rstcause_event_map
  import rstcause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wdt_expire,
  input  pwr_mode_e         pwr_mode,
  input  logic              sleep_entry,
  input  logic              idle_entry,
  input  logic              bor_event,
  input  logic              por_event,
  output logic [DATA_W-1:0] hw_set
);

  // Collect every event pulse of this cycle into one vector of bits to set.
  function automatic logic [DATA_W-1:0] build_set(
    input logic      wdt,
    input pwr_mode_e pm,
    input logic      es,
    input logic      ei,
    input logic      bor,
    input logic      por
  );
    logic [DATA_W-1:0] v;
    v = '0;
    if (wdt) begin
      v[BIT_WDTO] = 1'b1;
      if (pm == PM_SLEEP) v[BIT_SLEEP] = 1'b1;
      if (pm == PM_IDLE)  v[BIT_IDLE]  = 1'b1;
    end
    if (es)  v[BIT_SLEEP] = 1'b1;
    if (ei)  v[BIT_IDLE]  = 1'b1;
    if (bor) v[BIT_BOR]   = 1'b1;
    if (por) v[BIT_POR]   = 1'b1;
    return v;
  endfunction

  assign hw_set = build_set(wdt_expire, pwr_mode, sleep_entry, idle_entry,
                            bor_event, por_event);

endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
  import rstcause_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h1F,
  parameter logic [DATA_W-1:0] RST_VAL   = 32'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] status
);

  // Software result of one bus write to the given slot.
  function automatic logic [DATA_W-1:0] sw_apply(
    input alias_op_e         o,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd
  );
    case (o)
      OP_DIRECT: return wd;
      OP_CLR:    return cur & ~wd;
      OP_SET:    return cur | wd;
      default:   return cur ^ wd;
    endcase
  endfunction

  logic [DATA_W-1:0] sw_next;
  logic [DATA_W-1:0] flag_d;
  logic [DATA_W-1:0] flag_q;

  assign sw_next = wr_fire ? sw_apply(op, flag_q, wdata) : flag_q;
  // Hardware sets are merged after the software result, so an event always wins.
  assign flag_d  = (sw_next | hw_set) & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= RST_VAL & IMPL_MASK;
    else        flag_q <= flag_d;
  end

  assign status = flag_q;

  // Per-bit checks, one pair for each implemented flag.
  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    if (IMPL_MASK[i]) begin : g_impl
      p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[i] |=> status[i]);
      p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire && !hw_set[i]) |=> $stable(status[i]));
    end
  end

endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
  import rstcause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_word,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              wdt_expire,
  input  logic [1:0]        pwr_mode,
  input  logic              sleep_entry,
  input  logic              idle_entry,
  input  logic              bor_event,
  input  logic              por_event
);

  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] IMPL_MASK = (ONE << BIT_POR) | (ONE << BIT_BOR) |
                                            (ONE << BIT_IDLE) | (ONE << BIT_SLEEP) |
                                            (ONE << BIT_WDTO);
  localparam logic [DATA_W-1:0] RST_VAL   = (ONE << BIT_POR) | (ONE << BIT_BOR);

  // Named internal events, visible to the assertions.
  alias_op_e         op;
  logic              wr_fire;
  logic              rd_direct;
  logic [DATA_W-1:0] hw_set;
  logic [DATA_W-1:0] status;

  rstcause_alias_dec u_dec (
    .reg_word  (reg_word),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .op        (op),
    .wr_fire   (wr_fire),
    .rd_direct (rd_direct)
  );

  rstcause_event_map #(.DATA_W(DATA_W)) u_evt (
    .wdt_expire  (wdt_expire),
    .pwr_mode    (pwr_mode_e'(pwr_mode)),
    .sleep_entry (sleep_entry),
    .idle_entry  (idle_entry),
    .bor_event   (bor_event),
    .por_event   (por_event),
    .hw_set      (hw_set)
  );

  rstcause_flags #(
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK),
    .RST_VAL   (RST_VAL)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .op      (op),
    .wdata   (wdata),
    .hw_set  (hw_set),
    .status  (status)
  );

  // Only the direct slot returns the word; alias slots and idle cycles read zero.
  assign rdata = rd_direct ? status : '0;

  p_alias_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_word != 2'd0) |-> (rdata == '0));

  p_rsvd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((rdata & ~IMPL_MASK) == '0));

  p_set_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_word == 2'd2) |=>
      ((status & $past(wdata & IMPL_MASK)) == $past(wdata & IMPL_MASK)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_word == 2'd1 && hw_set == '0) |=>
      ((status & $past(wdata & IMPL_MASK)) == '0));

  p_wdt_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && pwr_mode == 2'b10) |=> (status[BIT_WDTO] && status[BIT_SLEEP]));

endmodule

// File: tb/sim_rstcause_reg.sv
`timescale 1ns/1ps
module sim_rstcause_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_expire = 1'b0;
  logic [1:0]  pwr_mode = 2'd0;
  logic        sleep_entry = 1'b0;
  logic        idle_entry = 1'b0;
  logic        bor_event = 1'b0;
  logic        por_event = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] model;

  always #2.5 clk = ~clk;

  rstcause_reg u0 (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .wdt_expire(wdt_expire), .pwr_mode(pwr_mode),
    .sleep_entry(sleep_entry), .idle_entry(idle_entry), .bor_event(bor_event),
    .por_event(por_event)
  );

  // Reference: bits the events must raise (R8, R9).
  function automatic logic [31:0] ref_hw(input logic wdt, input logic [1:0] pm,
                                         input logic es, input logic ei,
                                         input logic bor, input logic por);
    logic [31:0] v = '0;
    v[0] = por;
    v[1] = bor;
    v[2] = ei | (wdt & (pm == 2'b01));
    v[3] = es | (wdt & (pm == 2'b10));
    v[4] = wdt;
    return v;
  endfunction

  // Reference: bit-by-bit next word (R2-R5, R7, R10).
  function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic [1:0] w,
                                           input logic we, input logic [31:0] d,
                                           input logic [31:0] hw);
    logic [31:0] r = '0;
    for (int i = 0; i < 5; i++) begin
      logic b = cur[i];
      if (we) begin
        if (w == 2'd0) b = d[i];
        else if (d[i]) b = (w == 2'd1) ? 1'b0 : (w == 2'd2) ? 1'b1 : ~cur[i];
      end
      r[i] = b | hw[i];
    end
    return r;
  endfunction

  task automatic cyc(input logic [1:0] w, input logic we, input logic [31:0] d,
                     input logic wdt, input logic [1:0] pm, input logic es,
                     input logic ei, input logic bor, input logic por);
    @(negedge clk);
    reg_word = w; wr_en = we; wdata = d; wdt_expire = wdt; pwr_mode = pm;
    sleep_entry = es; idle_entry = ei; bor_event = bor; por_event = por;
    model = ref_next(model, w, we, d, ref_hw(wdt, pm, es, ei, bor, por));
    @(negedge clk);
    wr_en = 1'b0; wdt_expire = 1'b0; sleep_entry = 1'b0; idle_entry = 1'b0;
    bor_event = 1'b0; por_event = 1'b0; wdata = '0;
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    cyc(w, 1'b1, d, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input logic [1:0] w, input logic re, input logic [31:0] exp,
                        input string req);
    reg_word = w; rd_en = re;
    #1;
    n_vec++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: slot %0d rdata=%h expected=%h", req, w, rdata, exp);
    end
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    model = 32'h3;
    rd_chk(2'd0, 1'b1, 32'h0000_0003, "R1");
    rd_chk(2'd1, 1'b1, 32'h0, "R6");
    rd_chk(2'd2, 1'b1, 32'h0, "R6");
    rd_chk(2'd3, 1'b1, 32'h0, "R6");
    rd_chk(2'd0, 1'b0, 32'h0, "R6");
  endtask

  task automatic t_direct();
    wr(2'd0, 32'hFFFF_FFFF); rd_chk(2'd0, 1'b1, model, "R2 R7");
    wr(2'd0, 32'h0);         rd_chk(2'd0, 1'b1, model, "R2");
    wr(2'd0, 32'h0000_0015); rd_chk(2'd0, 1'b1, model, "R2");
    wr(2'd0, 32'hA5A5_0000); rd_chk(2'd0, 1'b1, model, "R7");
  endtask

  task automatic t_clear();
    wr(2'd0, 32'h1F);
    wr(2'd1, 32'h06);        rd_chk(2'd0, 1'b1, model, "R3");
    wr(2'd1, 32'hFFFF_FFE0); rd_chk(2'd0, 1'b1, model, "R3 R7");
    rd_chk(2'd1, 1'b1, 32'h0, "R6");
  endtask

  task automatic t_set();
    wr(2'd2, 32'h06);        rd_chk(2'd0, 1'b1, model, "R4");
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hFF00_0011); rd_chk(2'd0, 1'b1, model, "R4 R7");
  endtask

  task automatic t_invert();
    wr(2'd3, 32'h1F);        rd_chk(2'd0, 1'b1, model, "R5");
    wr(2'd3, 32'hFFFF_FF03); rd_chk(2'd0, 1'b1, model, "R5 R7");
    rd_chk(2'd3, 1'b1, 32'h0, "R6");
  endtask

  task automatic t_events();
    wr(2'd0, 32'h0);
    cyc(2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); rd_chk(2'd0, 1'b1, model, "R8");
    cyc(2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); rd_chk(2'd0, 1'b1, model, "R8");
    cyc(2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1); rd_chk(2'd0, 1'b1, model, "R8");
    cyc(2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); rd_chk(2'd0, 1'b1, model, "R8");
    cyc(2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); rd_chk(2'd0, 1'b1, model, "R8");
  endtask

  task automatic t_wdt();
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 32'h0);
      cyc(2'd0, 1'b0, 32'h0, 1'b1, 2'(m), 1'b0, 1'b0, 1'b0, 1'b0);
      rd_chk(2'd0, 1'b1, model, "R9");
    end
  endtask

  task automatic t_collide();
    wr(2'd0, 32'h0);
    cyc(2'd1, 1'b1, 32'h1F, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk(2'd0, 1'b1, model, "R10");
    cyc(2'd0, 1'b1, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_chk(2'd0, 1'b1, model, "R10");
    cyc(2'd3, 1'b1, 32'h03, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_chk(2'd0, 1'b1, model, "R10");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    model = 32'h3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_clear();
    t_set();
    t_invert();
    t_events();
    t_wdt();
    t_collide();
    finish_run();
  end

endmodule